// File: doc/BRIEF.md
# CRC-16 Byte Engine with Block Walker

This block computes a 16-bit cyclic redundancy check with generator x^16 + x^12 + x^5 + 1 (0x1021). It takes one byte per clock, either straight from a byte port with a valid strobe or from a synchronous memory read port that the block drives itself. The start value is chosen by a single select input, giving all zeros or all ones. A reverse input mirrors each byte before it is folded in.

In automatic mode the block takes a start block index and a block count. Each block is 256 bytes and starts on a 256-byte boundary. The block reads every address in turn, folds each returned byte into the running value, and marks completion with a one-cycle done pulse. While that walk is running, the byte port is locked out and any attempt to use it sets a sticky error flag.

Top module: `crc16_unit`

## Requirements
- R1: While reset is asserted, and right after it, crc_out is 0x0000 and busy, done, err and mem_rd_en are all low.
- R2: When idle, a byte_vld cycle folds byte_in into the value, most significant bit first, with generator 0x1021 and no final inversion. crc_out shows the new value in the next cycle. Starting from 0x0000, the ASCII bytes "123456789" give 0x31C3. With no command present, crc_out holds its value.
- R3: When idle, reload sets the value to 0xFFFF if seed_ones is 1 and to 0x0000 if it is 0. Starting from 0xFFFF, "123456789" gives 0x29B1. When reload and byte_vld arrive in the same cycle, reload wins and the byte is dropped.
- R4: With rev_en at 1, each byte is mirrored before folding, so bit 0 enters first. From seed 0x0000, the byte 0x80 gives 0x1021.
- R5: When idle, auto_go loads the selected seed and raises busy. The block then reads blk_count*256 bytes, one address per cycle, in ascending order from blk_first*256. mem_rd_en is high only while busy.
- R6: The memory returns mem_rd_data in the cycle after mem_rd_en. Each returned byte is folded in exactly as a port byte is, with rev_en applied.
- R7: done is a one-cycle pulse. It comes in the same cycle in which busy falls and crc_out holds the final value of the walk. With blk_count 0, done comes in the cycle after auto_go, no reads are made, and crc_out equals the seed.
- R8: A byte_vld while busy is dropped, and err is high from the next cycle. err stays set until reset or until an idle reload.
- R9: While busy, auto_go, reload and changes to seed_ones have no effect on the walk's addresses or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_ones | input | 1 | Seed select: 1 gives 0xFFFF, 0 gives 0x0000 |
| reload | input | 1 | Load the selected seed (idle only) |
| rev_en | input | 1 | Mirror each byte before folding |
| byte_vld | input | 1 | byte_in is valid this cycle |
| byte_in | input | 8 | Data byte |
| auto_go | input | 1 | Start an automatic block walk |
| blk_first | input | BLK_W | Index of the first 256-byte block |
| blk_count | input | CNT_W | Number of blocks to walk |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | BLK_W+8 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the strobe |
| crc_out | output | 16 | Current CRC value |
| busy | output | 1 | Automatic walk in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| err | output | 1 | Sticky flag for a byte offered while busy |

## Verification
Some properties are checked on every cycle. Reads happen only during a walk, and consecutive read addresses step by one. done lasts a single cycle and never overlaps busy. err rises after a byte is offered while busy and stays set until an idle reload. An idle reload lands the selected seed, and crc_out holds when no command is present. The bench scenarios cover what a property cannot: the CRC arithmetic against an independent model and known check values, byte mirroring, the exact read count and starting boundary of a walk, the zero-block case, and the way a walk shrugs off commands that arrive mid-run.

// File: rtl/crc16_unit.sv
module crc16_unit #(
  parameter int BLK_W = 8,
  parameter int CNT_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_ones,
  input  logic              reload,
  input  logic              rev_en,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              auto_go,
  input  logic [BLK_W-1:0]  blk_first,
  input  logic [CNT_W-1:0]  blk_count,
  output logic              mem_rd_en,
  output logic [BLK_W+7:0]  mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic [15:0]       crc_out,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam int ADDR_W = BLK_W + 8;
  localparam int LEN_W  = CNT_W + 8;
  localparam logic [15:0] POLY = 16'h1021;

  logic [15:0]       crc_q;
  logic              busy_q, done_q, err_q, pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  issue_q, fold_q;

  function automatic logic [15:0] fold8(input logic [15:0] c_in, input logic [7:0] d,
                                        input logic rev);
    logic [15:0] c;
    logic [7:0]  x;
    logic        fb;
    c = c_in;
    for (int i = 0; i < 8; i++) x[i] = rev ? d[7-i] : d[i];
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ x[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  wire [15:0] seed = seed_ones ? 16'hFFFF : 16'h0000;

  assign mem_rd_en   = busy_q && (issue_q != '0);
  assign mem_rd_addr = addr_q;
  assign crc_out     = crc_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign err         = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      issue_q <= '0;
      fold_q  <= '0;
    end else begin
      done_q <= 1'b0;
      pend_q <= mem_rd_en;
      if (busy_q) begin
        if (byte_vld) err_q <= 1'b1;
        if (mem_rd_en) begin
          addr_q  <= addr_q + 1'b1;
          issue_q <= issue_q - 1'b1;
        end
        if (pend_q) begin
          crc_q  <= fold8(crc_q, mem_rd_data, rev_en);
          fold_q <= fold_q - 1'b1;
          if (fold_q == LEN_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else if (auto_go) begin
        crc_q   <= seed;
        addr_q  <= {blk_first, 8'h00};
        issue_q <= {blk_count, 8'h00};
        fold_q  <= {blk_count, 8'h00};
        if (blk_count == '0) done_q <= 1'b1;
        else busy_q <= 1'b1;
      end else if (reload) begin
        crc_q <= seed;
        err_q <= 1'b0;
      end else if (byte_vld) begin
        crc_q <= fold8(crc_q, byte_in, rev_en);
      end
    end
  end

  AST_RD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> busy); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |-> mem_rd_addr == ADDR_W'($past(mem_rd_addr) + 1'b1)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    busy && byte_vld |=> err); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err && !(!busy && reload && !auto_go) |=> err); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !byte_vld && !reload && !auto_go |=> $stable(crc_out)); // R2
  AST_RELOAD_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && reload && !auto_go |=> crc_out == ($past(seed_ones) ? 16'hFFFF : 16'h0000)); // R3
endmodule

// File: tb/crc16_unit_tb.sv
module crc16_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int          kind;
    logic [15:0] val;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_ones = 1'b0, reload = 1'b0, rev_en = 1'b0, byte_vld = 1'b0, auto_go = 1'b0;
  logic [7:0]  byte_in = '0;
  logic [7:0]  blk_first = '0;
  logic [8:0]  blk_count = '0;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_q = '0;
  logic [15:0] crc_out;
  logic        busy, done, err;

  exp_t        sb_q[$];
  int          vectors = 0;
  int          fails = 0;
  int          reads = 0;
  logic [15:0] exp_addr = '0;
  logic [15:0] model = '0;
  bit          ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_unit #(.BLK_W(8), .CNT_W(9)) dut_i (
    .clk(clk), .rst_n(rst_n), .seed_ones(seed_ones), .reload(reload), .rev_en(rev_en),
    .byte_vld(byte_vld), .byte_in(byte_in), .auto_go(auto_go), .blk_first(blk_first),
    .blk_count(blk_count), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_q), .crc_out(crc_out), .busy(busy), .done(done), .err(err)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return 8'(a[7:0] * 8'd29) + 8'(a[15:8] * 8'd11) + 8'd3;
  endfunction

  function automatic logic [15:0] ref_fold(input logic [15:0] c_in, input logic [7:0] b,
                                           input logic rev);
    logic [15:0] c;
    logic [7:0]  bb;
    for (int i = 0; i < 8; i++) bb[i] = rev ? b[7-i] : b[i];
    c = c_in ^ {bb, 8'h00};
    for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_q <= pat(mem_rd_addr);

  always @(negedge clk) begin
    if (mem_rd_en) begin
      vectors++;
      if (mem_rd_addr !== exp_addr) begin
        fails++;
        $display("FAIL R5 read address actual %h expected %h", mem_rd_addr, exp_addr);
      end
      exp_addr++;
      reads++;
    end
  end

  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      logic [15:0] act;
      e = sb_q.pop_front();
      case (e.kind)
        0: act = crc_out;
        1: act = {15'd0, busy};
        2: act = {15'd0, done};
        3: act = {15'd0, err};
        default: act = {15'd0, mem_rd_en};
      endcase
      vectors++;
      if (act !== e.val) begin
        fails++;
        $display("FAIL %s kind %0d actual %h expected %h", e.req, e.kind, act, e.val);
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic push(int k, logic [15:0] v, string r);
    exp_t e;
    e.kind = k; e.val = v; e.req = r;
    sb_q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic send(logic [7:0] b, string r);
    byte_in = b; byte_vld = 1'b1;
    tick();
    byte_vld = 1'b0;
    model = ref_fold(model, b, rev_en);
    push(0, model, r);
  endtask

  task automatic do_reload(logic ones);
    seed_ones = ones; reload = 1'b1;
    tick();
    reload = 1'b0;
    model = ones ? 16'hFFFF : 16'h0000;
    push(0, model, "R3");
  endtask

  task automatic run_auto(logic [7:0] blk, logic [8:0] cnt, bit disturb, string r);
    logic [15:0] a;
    model = seed_ones ? 16'hFFFF : 16'h0000;
    a = {blk, 8'h00};
    for (int n = 0; n < int'(cnt) * 256; n++) begin
      model = ref_fold(model, pat(a), rev_en);
      a++;
    end
    exp_addr = {blk, 8'h00};
    reads = 0;
    blk_first = blk; blk_count = cnt; auto_go = 1'b1;
    tick();
    auto_go = 1'b0;
    push(1, 16'd1, "R5");
    if (disturb) begin
      repeat (5) tick();
      byte_in = 8'hA5; byte_vld = 1'b1; auto_go = 1'b1; reload = 1'b1;
      blk_first = blk + 8'd7; seed_ones = ~seed_ones;
      tick();
      byte_vld = 1'b0; auto_go = 1'b0; reload = 1'b0; seed_ones = ~seed_ones;
      push(3, 16'd1, "R8");
    end
    while (!done) tick();
    push(2, 16'd1, "R7");
    push(1, 16'd0, "R7");
    push(0, model, disturb ? "R9" : r);
    tick();
    push(2, 16'd0, "R7");
    vectors++;
    if (reads != int'(cnt) * 256) begin
      fails++;
      $display("FAIL R5 read count actual %0d expected %0d", reads, int'(cnt) * 256);
    end
  endtask

  initial begin
    string s;
    tick();
    push(0, 16'h0000, "R1"); push(1, 16'd0, "R1"); push(2, 16'd0, "R1");
    push(3, 16'd0, "R1"); push(4, 16'd0, "R1");
    tick();
    rst_n = 1'b1;
    tick();
    push(0, 16'h0000, "R1"); push(1, 16'd0, "R1");

    s = "123456789";
    do_reload(1'b0);
    for (int i = 0; i < 9; i++) send(s[i], "R2");
    push(0, 16'h31C3, "R2");
    tick();
    push(0, 16'h31C3, "R2");

    do_reload(1'b1);
    for (int i = 0; i < 9; i++) send(s[i], "R3");
    push(0, 16'h29B1, "R3");

    rev_en = 1'b1;
    do_reload(1'b0);
    send(8'h80, "R4");
    push(0, 16'h1021, "R4");
    send(8'h3C, "R4");
    send(8'hE1, "R4");
    rev_en = 1'b0;

    seed_ones = 1'b1; reload = 1'b1; byte_vld = 1'b1; byte_in = 8'h55;
    tick();
    reload = 1'b0; byte_vld = 1'b0;
    model = 16'hFFFF;
    push(0, model, "R3");

    seed_ones = 1'b1;
    run_auto(8'h03, 9'd1, 1'b1, "R5");
    tick();
    push(3, 16'd1, "R8");
    do_reload(1'b0);
    push(3, 16'd0, "R8");

    seed_ones = 1'b0; rev_en = 1'b1;
    run_auto(8'hFE, 9'd2, 1'b0, "R6");
    rev_en = 1'b0;

    seed_ones = 1'b1;
    blk_first = 8'h10; blk_count = 9'd0; auto_go = 1'b1;
    tick();
    auto_go = 1'b0;
    push(2, 16'd1, "R7"); push(1, 16'd0, "R7");
    push(0, 16'hFFFF, "R7"); push(4, 16'd0, "R7");

    tick();
    tick();
    finish_run();
  end
endmodule